// File: doc/BRIEF.md
# Hart debug status tracker

This block reports the run state of one hart to an external debug controller. It drives three mutually exclusive status lines: the hart is fresh out of reset, the hart is running, or the hart is halted in debug mode. It also reports the program counter of the most recently retired instruction, qualified by a valid bit, and it raises a halt-pending line that asks the core to enter debug mode.

After reset the block holds the reset status until the fetch-enable input is seen high at a clock edge. Fetch enable is then ignored until the next reset. A fixed settling interval of `UNAVAIL_CYC` cycles follows, after which the halted line follows the core's debug-mode flag and the running line is its complement. A halt request that is already high at any edge from reset release up to and including the edge that samples fetch enable is remembered. The status then moves from reset straight to halted and never shows running. The remembered request is dropped once the core reports debug mode. The halt request is level-sensitive. A requester must keep it high until halted is seen.

Top module: `hart_status_tracker`

## Requirements
- R1: In every cycle exactly one of `stat_reset`, `stat_running` and `stat_halted` is high, including while `rst_n` is low.
- R2: `stat_reset` is high while `rst_n` is low and stays high after release until `fetch_en` is sampled high at a rising edge. Levels of `fetch_en` or `halt_req` during reset have no effect.
- R3: If edge k is the first edge after release with `fetch_en` high, `stat_reset` is high up to edge k+`UNAVAIL_CYC` and low after it (default 2).
- R4: Once `stat_reset` is low and no early halt is held, `stat_halted` equals `core_in_debug` and `stat_running` is its inverse.
- R5: If `halt_req` is high at any edge from release through edge k, `stat_reset` falls directly into `stat_halted`. Halted is then held regardless of `core_in_debug` until an edge after k samples `core_in_debug` high. After that, R4 applies.
- R6: A `halt_req` that first rises after edge k gets no early treatment. The status follows `core_in_debug`, so running may be shown before halted.
- R7: `halt_pending` is low until `fetch_en` has been sampled. After that it is high exactly when `core_in_debug` is low and either `halt_req` is high or an early halt (R5) is held.
- R8: Dropping `fetch_en` after it has been sampled changes no output until the next reset.
- R9: `last_pc_valid` is low after reset and goes high after the first edge with `retire_valid` high. `last_pc` shows the `retire_pc` of the latest such edge from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| fetch_en | input | 1 | Permission for the hart to start fetching |
| core_in_debug | input | 1 | Core reports it is in debug mode |
| halt_req | input | 1 | Level-sensitive halt request from the debug controller |
| retire_valid | input | 1 | An instruction retires this cycle |
| retire_pc | input | PC_W | PC of the retiring instruction |
| stat_reset | output | 1 | Status: hart has been reset, not yet available |
| stat_running | output | 1 | Status: hart running |
| stat_halted | output | 1 | Status: hart halted in debug mode |
| halt_pending | output | 1 | Request to the core to enter debug mode |
| last_pc | output | PC_W | PC of the last retired instruction |
| last_pc_valid | output | 1 | `last_pc` holds a retired PC |

## Verification
A wrong phase register shows at the status lines in the cycle after the faulty edge. An early or late fall of `stat_reset` is therefore caught on the first miscounted settling cycle. A lost or stuck early-halt flag shows as a running cycle when `stat_reset` falls, or as halted staying high once the debug flag drops. A wrong capture register shows on `last_pc` one cycle after the retire strobe. The sweep varies fetch timing, halt timing relative to fetch, the core's debug response and a fetch-enable drop, and compares every output every cycle.

// File: rtl/hst_pkg.sv
package hst_pkg;

  typedef enum logic [1:0] {
    PH_WAIT_FETCH = 2'd0,
    PH_SETTLE     = 2'd1,
    PH_LIVE       = 2'd2
  } hst_phase_e;

endpackage

// File: rtl/hst_startup_seq.sv
module hst_startup_seq
  import hst_pkg::*;
#(
  parameter int UNAVAIL_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fetch_en,
  input  logic       halt_req,
  input  logic       core_in_debug,
  output hst_phase_e phase,
  output logic       early_halt
);

  localparam int CNT_W = (UNAVAIL_CYC > 1) ? $clog2(UNAVAIL_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(UNAVAIL_CYC - 1);

  hst_phase_e phase_q, phase_d;
  logic       phase_en;
  logic       early_q, early_d, early_en;
  logic       settle_done;

  // settling counter, only built when the interval exceeds one cycle
  generate
    if (UNAVAIL_CYC > 1) begin : g_cnt
      logic [CNT_W-1:0] cnt_q, cnt_d;
      logic             cnt_en;

      always_comb begin
        cnt_en = (phase_q == PH_SETTLE) || (cnt_q != '0);
        cnt_d  = ((phase_q == PH_SETTLE) && (cnt_q != CNT_LAST)) ? cnt_q + 1'b1 : '0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else if (cnt_en) begin
          cnt_q <= cnt_d;
        end
      end

      assign settle_done = (cnt_q == CNT_LAST);
    end else begin : g_nocnt
      assign settle_done = 1'b1;
    end
  endgenerate

  // phase next state
  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_WAIT_FETCH: if (fetch_en)    phase_d = PH_SETTLE;
      PH_SETTLE:     if (settle_done) phase_d = PH_LIVE;
      PH_LIVE:                        phase_d = PH_LIVE;
      default:                        phase_d = PH_WAIT_FETCH;
    endcase
    phase_en = (phase_d != phase_q);
  end

  // early halt: captured only before/at fetch sampling, released on debug entry
  always_comb begin
    early_d  = early_q;
    early_en = 1'b0;
    if ((phase_q == PH_WAIT_FETCH) && halt_req) begin
      early_d  = 1'b1;
      early_en = 1'b1;
    end else if ((phase_q != PH_WAIT_FETCH) && core_in_debug && early_q) begin
      early_d  = 1'b0;
      early_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_WAIT_FETCH;
    end else if (phase_en) begin
      phase_q <= phase_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      early_q <= 1'b0;
    end else if (early_en) begin
      early_q <= early_d;
    end
  end

  assign phase      = phase_q;
  assign early_halt = early_q;

endmodule

// File: rtl/hst_status_enc.sv
module hst_status_enc
  import hst_pkg::*;
(
  input  hst_phase_e phase,
  input  logic       early_halt,
  input  logic       core_in_debug,
  input  logic       halt_req,
  output logic       stat_reset,
  output logic       stat_running,
  output logic       stat_halted,
  output logic       halt_pending
);

  logic live;
  logic halt_view;

  always_comb begin
    live         = (phase == PH_LIVE);
    halt_view    = core_in_debug | early_halt;
    stat_reset   = ~live;
    stat_halted  = live & halt_view;
    stat_running = live & ~halt_view;
    halt_pending = (phase != PH_WAIT_FETCH) & ~core_in_debug & (halt_req | early_halt);
  end

endmodule

// File: rtl/hst_retire_capture.sv
module hst_retire_capture #(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            retire_valid,
  input  logic [PC_W-1:0] retire_pc,
  output logic [PC_W-1:0] last_pc,
  output logic            last_pc_valid
);

  logic [PC_W-1:0] pc_q;
  logic            vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      vld_q <= 1'b0;
    end else if (retire_valid) begin
      pc_q  <= retire_pc;
      vld_q <= 1'b1;
    end
  end

  assign last_pc       = pc_q;
  assign last_pc_valid = vld_q;

endmodule

// File: rtl/hart_status_tracker.sv
module hart_status_tracker
  import hst_pkg::*;
#(
  parameter int PC_W        = 32,
  parameter int UNAVAIL_CYC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fetch_en,
  input  logic            core_in_debug,
  input  logic            halt_req,
  input  logic            retire_valid,
  input  logic [PC_W-1:0] retire_pc,
  output logic            stat_reset,
  output logic            stat_running,
  output logic            stat_halted,
  output logic            halt_pending,
  output logic [PC_W-1:0] last_pc,
  output logic            last_pc_valid
);

  hst_phase_e phase;
  logic       early_halt;

  hst_startup_seq #(.UNAVAIL_CYC(UNAVAIL_CYC)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .fetch_en      (fetch_en),
    .halt_req      (halt_req),
    .core_in_debug (core_in_debug),
    .phase         (phase),
    .early_halt    (early_halt)
  );

  hst_status_enc u_enc (
    .phase         (phase),
    .early_halt    (early_halt),
    .core_in_debug (core_in_debug),
    .halt_req      (halt_req),
    .stat_reset    (stat_reset),
    .stat_running  (stat_running),
    .stat_halted   (stat_halted),
    .halt_pending  (halt_pending)
  );

  hst_retire_capture #(.PC_W(PC_W)) u_cap (
    .clk           (clk),
    .rst_n         (rst_n),
    .retire_valid  (retire_valid),
    .retire_pc     (retire_pc),
    .last_pc       (last_pc),
    .last_pc_valid (last_pc_valid)
  );

endmodule

// File: rtl/hst_status_checker.sv
module hst_status_checker
  import hst_pkg::*;
#(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            core_in_debug,
  input logic            retire_valid,
  input logic [PC_W-1:0] retire_pc,
  input logic            stat_reset,
  input logic            stat_running,
  input logic            stat_halted,
  input logic            halt_pending,
  input logic [PC_W-1:0] last_pc,
  input logic            last_pc_valid,
  input hst_phase_e      phase,
  input logic            early_halt
);

  // R1
  p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({stat_reset, stat_running, stat_halted}) == 1);

  // R8: once available, the reset status never returns before a reset
  p_stay_avail_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_reset |=> !stat_reset);

  // R4
  p_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_reset && !early_halt) |-> (stat_halted == core_in_debug));

  // R5
  p_direct_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(stat_reset) && early_halt) |-> stat_halted);

  // R7
  p_nopend_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WAIT_FETCH) |-> !halt_pending);

  // R9
  p_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
    retire_valid |=> (last_pc_valid && (last_pc == $past(retire_pc))));

  // R9
  p_valid_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    last_pc_valid |=> last_pc_valid);

endmodule

bind hart_status_tracker hst_status_checker #(.PC_W(PC_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .core_in_debug (core_in_debug),
  .retire_valid  (retire_valid),
  .retire_pc     (retire_pc),
  .stat_reset    (stat_reset),
  .stat_running  (stat_running),
  .stat_halted   (stat_halted),
  .halt_pending  (halt_pending),
  .last_pc       (last_pc),
  .last_pc_valid (last_pc_valid),
  .phase         (phase),
  .early_halt    (early_halt)
);

// File: tb/tb_hart_status_tracker.sv
module tb_hart_status_tracker;

  localparam int PC_W   = 32;
  localparam int SETTLE = 2;
  localparam int NEVER  = 999;
  localparam int RUN_E  = 16;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            fetch_en, core_in_debug, halt_req, retire_valid;
  logic [PC_W-1:0] retire_pc;
  logic            stat_reset, stat_running, stat_halted, halt_pending;
  logic [PC_W-1:0] last_pc;
  logic            last_pc_valid;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  hart_status_tracker #(.PC_W(PC_W), .UNAVAIL_CYC(SETTLE)) dut (
    .clk(clk), .rst_n(rst_n), .fetch_en(fetch_en), .core_in_debug(core_in_debug),
    .halt_req(halt_req), .retire_valid(retire_valid), .retire_pc(retire_pc),
    .stat_reset(stat_reset), .stat_running(stat_running), .stat_halted(stat_halted),
    .halt_pending(halt_pending), .last_pc(last_pc), .last_pc_valid(last_pc_valid)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pcv(input int s, input int e);
    return 32'(s * 4096 + e * 4);
  endfunction

  // inputs presented before edge e
  task automatic drive(input int s, input int e, input int f, input int hs,
                       input int c, input bit drop);
    fetch_en      = drop ? (e == f) : (e >= f);
    halt_req      = (e >= hs);
    core_in_debug = (e >= c);
    retire_valid  = (e % 3 == 2);
    retire_pc     = pcv(s, e);
  endtask

  initial begin
    int s;
    s = 0;
    rst_n = 1'b0;
    fetch_en = 1'b0; core_in_debug = 1'b0; halt_req = 1'b0;
    retire_valid = 1'b0; retire_pc = '0;
    for (int f = 1; f <= 4; f++) begin
      for (int hsel = 0; hsel < 5; hsel++) begin
        for (int dsel = 0; dsel < 2; dsel++) begin
          for (int dr = 0; dr < 2; dr++) begin
            int hs, c;
            bit early;
            string st_req;
            s++;
            case (hsel)
              0: hs = f - 1;
              1: hs = f;
              2: hs = f + 1;
              3: hs = f + 3;
              default: hs = NEVER;
            endcase
            if (hs == NEVER) c = (dsel == 0) ? f + 4 : NEVER;
            else             c = (dsel == 0) ? ((hs > f) ? hs : f) + 3 : NEVER;
            early = (hs <= f);
            if (early)           st_req = "R5";
            else if (hs < NEVER) st_req = "R6";
            else                 st_req = "R4";

            // reset with fetch and halt already high: both must be ignored (R2)
            @(negedge clk);
            rst_n = 1'b0;
            fetch_en = 1'b1; halt_req = 1'b1; core_in_debug = 1'b0;
            retire_valid = 1'b1; retire_pc = 32'hDEAD_BEEF;
            @(negedge clk);
            @(negedge clk);
            chk("R2", "reset status in reset", 32'(stat_reset), 32'd1);
            chk("R1", "onehot in reset",
                32'($countones({stat_reset, stat_running, stat_halted})), 32'd1);
            chk("R7", "pending in reset", 32'(halt_pending), 32'd0);
            chk("R9", "pc valid in reset", 32'(last_pc_valid), 32'd0);

            rst_n = 1'b1;
            drive(s, 1, f, hs, c, dr[0]);
            chk("R2", "reset status at release", 32'(stat_reset), 32'd1);
            chk("R9", "pc valid at release", 32'(last_pc_valid), 32'd0);

            for (int e = 1; e <= RUN_E; e++) begin
              bit live, fetched, ear, dbg, hr, exp_h, exp_p, exp_v;
              int lastr;
              string r_req;
              @(negedge clk);
              live    = (e >= f + SETTLE);
              fetched = (e >= f);
              dbg     = (e >= c);
              hr      = (e >= hs);
              ear     = early && (e >= hs) && !((e >= c) && (e >= f + 1));
              exp_h   = live && (dbg || ear);
              exp_p   = fetched && !dbg && (hr || ear);
              exp_v   = (e >= 2);
              lastr   = e - ((e - 2) % 3);
              r_req   = (dr && e > f) ? "R8" : st_req;

              chk("R1", "onehot",
                  32'($countones({stat_reset, stat_running, stat_halted})), 32'd1);
              chk((e < f) ? "R2" : ((dr && e > f) ? "R8" : "R3"), "reset status",
                  32'(stat_reset), 32'(!live));
              chk(r_req, "halted", 32'(stat_halted), 32'(exp_h));
              chk(r_req, "running", 32'(stat_running), 32'(live && !exp_h));
              chk("R7", "halt pending", 32'(halt_pending), 32'(exp_p));
              chk("R9", "pc valid", 32'(last_pc_valid), 32'(exp_v));
              if (exp_v) chk("R9", "last pc", last_pc, pcv(s, lastr));

              drive(s, e + 1, f, hs, c, dr[0]);
            end
          end
        end
      end
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule